// File: doc/BRIEF.md
# Trace Cache with Path Matching

This block keeps recently retired dynamic instruction sequences (traces), each of which may cross several non-contiguous basic blocks. A fetch unit presents a fetch address and the predicted outcomes of the next two branches. When a stored trace starts at that address and its recorded branch outcomes agree with the predictions, the whole trace is returned in one response. The response carries the instruction words, how many are valid, and where fetch should continue. If only the leading prediction agrees, the block returns the part of the trace that ends just after the last agreeing branch. A miss tells the fetch unit to use the ordinary instruction cache at the same address.

Traces are built from the retirement stream. Each retired instruction is presented with its address, its word, whether it is a branch, the resolved direction, and the address of the instruction that follows it dynamically. A fill buffer collects these instructions. It closes the trace when eight instructions have been gathered or when the third branch arrives, whichever comes first. The completed line is then written in that same cycle. Storage has sixteen direct-mapped lines, indexed by the low four bits of the start address. Addresses count instruction words.

Top module: `trace_cache`

## Requirements
- R1: After reset no line is valid, `rsp_valid` is 0, and every lookup misses.
- R2: A lookup is a full hit when the line at its index is valid, the tag (address bits above the low four) matches, and every recorded branch outcome among the first two agrees with `lk_pred`. Bit 0 of `lk_pred` is the first branch and 1 means taken. The response is registered and appears in the cycle after the request. A full hit returns the stored count, the words (word i in bits [32i+31:32i], slots beyond the count zero) and the trace exit address.
- R3: A lookup whose line is invalid or whose tag differs gives `rsp_hit`=0, `rsp_partial`=0, count 0, and `rsp_next` equal to the looked-up address.
- R4: If the first recorded outcome agrees and the second disagrees, the response is a partial hit. Its count is the first branch's position plus one, its words are that prefix only, and `rsp_next` is the address that followed the first branch when the trace was recorded.
- R5: If the first recorded outcome disagrees with `lk_pred[0]`, the lookup misses.
- R6: Prediction bits beyond the number of branches recorded in a trace do not affect the result.
- R7: The fill buffer closes a trace when its eighth instruction is appended. The exit address is the follower address of that instruction.
- R8: The fill buffer closes a trace when its third branch is appended. That branch is the last word of the trace, and its follower address is the exit address.
- R9: A closed trace is written in the cycle its last instruction is presented. A lookup in that same cycle to the same line sees the old contents, and a lookup in the next cycle sees the new trace.
- R10: A newly written trace replaces whatever trace occupied its line, even one with a different tag.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address of the lookup |
| lk_pred | input | 2 | Predicted outcomes of the next two branches, bit 0 first, 1 = taken |
| fill_valid | input | 1 | A retired instruction is presented |
| fill_pc | input | 32 | Address of the retired instruction |
| fill_instr | input | 32 | Instruction word |
| fill_is_br | input | 1 | The instruction is a conditional branch |
| fill_taken | input | 1 | Resolved direction of the branch |
| fill_next | input | 32 | Address of the dynamically following instruction |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Full or partial hit |
| rsp_partial | output | 1 | Only a prefix is supplied |
| rsp_count | output | 4 | Number of valid words |
| rsp_words | output | 256 | Eight instruction words, word 0 lowest |
| rsp_next | output | 32 | Next fetch address |

## Verification
A lookup and the write of a completing fill can land in the same cycle on the same line. This is the case that decides whether fetch sees a stale or a fresh trace. The bench arranges this on purpose. It presents the eighth instruction of a new trace, whose start address shares the index of an existing trace, together with a lookup of the existing trace. That lookup must still return the old full hit. The next two lookups must show the old trace gone and the new one present.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int TC_N     = 8;
    localparam int TC_M     = 3;
    localparam int TC_LINES = 16;
    localparam int TC_AW    = 32;
    localparam int TC_IW    = 32;

    localparam int TC_NF   = TC_M - 1;
    localparam int CNTW    = $clog2(TC_N + 1);
    localparam int POSW    = $clog2(TC_N);
    localparam int NBW     = $clog2(TC_M + 1);
    localparam int IDXW    = $clog2(TC_LINES);
    localparam int TAGW    = TC_AW - IDXW;

    typedef logic [TC_N-1:0][TC_IW-1:0] words_t;

    typedef struct packed {
        logic                          valid;
        logic [TAGW-1:0]               tag;
        logic [NBW-1:0]                nbr;
        logic [TC_NF-1:0]              flags;
        logic [CNTW-1:0]               cnt;
        words_t                        words;
        logic [TC_NF-1:0][POSW-1:0]    pos;
        logic [TC_NF-1:0][TC_AW-1:0]   nxt;
        logic [TC_AW-1:0]              exitpc;
    } line_t;

    typedef struct packed {
        logic [CNTW-1:0]               cnt;
        logic [NBW-1:0]                nbr;
        logic [TC_AW-1:0]              start;
        words_t                        words;
        logic [TC_NF-1:0]              flags;
        logic [TC_NF-1:0][POSW-1:0]    pos;
        logic [TC_NF-1:0][TC_AW-1:0]   nxt;
    } fbuf_t;
endpackage

// File: rtl/tc_fill_buf.sv
module tc_fill_buf
    import tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic [TC_AW-1:0] fill_pc,
    input  logic [TC_IW-1:0] fill_instr,
    input  logic             fill_is_br,
    input  logic             fill_taken,
    input  logic [TC_AW-1:0] fill_next,
    output logic             wr_en,
    output logic [IDXW-1:0]  wr_idx,
    output line_t            wr_line
);
    fbuf_t fb_d, fb_q;

    always_comb begin
        logic [POSW-1:0] slot;
        logic            close;
        fb_d    = fb_q;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_line = '0;
        slot    = fb_q.cnt[POSW-1:0];
        close   = 1'b0;
        if (fill_valid) begin
            if (fb_q.cnt == '0) fb_d.start = fill_pc;
            fb_d.words[slot] = fill_instr;
            if (fill_is_br) begin
                for (int i = 0; i < TC_NF; i++) begin
                    if (i == int'(fb_q.nbr)) begin
                        fb_d.flags[i] = fill_taken;
                        fb_d.pos[i]   = slot;
                        fb_d.nxt[i]   = fill_next;
                    end
                end
                fb_d.nbr = fb_q.nbr + NBW'(1);
            end
            fb_d.cnt = fb_q.cnt + CNTW'(1);
            close = (int'(fb_q.cnt) == TC_N - 1) ||
                    (fill_is_br && int'(fb_q.nbr) == TC_M - 1);
            if (close) begin
                wr_en          = 1'b1;
                wr_idx         = fb_d.start[IDXW-1:0];
                wr_line.valid  = 1'b1;
                wr_line.tag    = fb_d.start[TC_AW-1:IDXW];
                wr_line.nbr    = fb_d.nbr;
                wr_line.flags  = fb_d.flags;
                wr_line.cnt    = fb_d.cnt;
                wr_line.words  = fb_d.words;
                wr_line.pos    = fb_d.pos;
                wr_line.nxt    = fb_d.nxt;
                wr_line.exitpc = fill_next;
                fb_d           = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end
endmodule

// File: rtl/tc_store.sv
module tc_store
    import tc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  line_t           wr_line,
    input  logic [IDXW-1:0] rd_idx,
    output line_t           rd_line
);
    line_t mem_q [TC_LINES];

    assign rd_line = mem_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TC_LINES; i++) mem_q[i].valid <= 1'b0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/tc_match.sv
module tc_match
    import tc_pkg::*;
(
    input  line_t             line,
    input  logic [TAGW-1:0]   lk_tag,
    input  logic [TC_NF-1:0]  lk_pred,
    output logic              hit,
    output logic              partial,
    output logic [CNTW-1:0]   count,
    output words_t            words,
    output logic [TC_AW-1:0]  next
);
    always_comb begin
        int first_mis;
        logic tag_ok;
        tag_ok    = line.valid && (line.tag == lk_tag);
        first_mis = TC_NF;
        for (int i = TC_NF - 1; i >= 0; i--) begin
            if (i < int'(line.nbr) && line.flags[i] != lk_pred[i]) first_mis = i;
        end
        hit     = 1'b0;
        partial = 1'b0;
        count   = '0;
        next    = '0;
        words   = '0;
        if (tag_ok && first_mis != 0) begin
            hit = 1'b1;
            if (first_mis == TC_NF) begin
                count = line.cnt;
                next  = line.exitpc;
            end else begin
                partial = 1'b1;
                count   = CNTW'(line.pos[first_mis-1]) + CNTW'(1);
                next    = line.nxt[first_mis-1];
            end
            for (int w = 0; w < TC_N; w++) begin
                if (w < int'(count)) words[w] = line.words[w];
            end
        end
    end
endmodule

// File: rtl/trace_cache.sv
module trace_cache
    import tc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [31:0]            lk_addr,
    input  logic [1:0]             lk_pred,
    input  logic                   fill_valid,
    input  logic [31:0]            fill_pc,
    input  logic [31:0]            fill_instr,
    input  logic                   fill_is_br,
    input  logic                   fill_taken,
    input  logic [31:0]            fill_next,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_partial,
    output logic [3:0]             rsp_count,
    output logic [255:0]           rsp_words,
    output logic [31:0]            rsp_next
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             partial;
        logic [CNTW-1:0]  cnt;
        words_t           words;
        logic [TC_AW-1:0] next;
    } rsp_t;

    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    line_t           wr_line;
    line_t           rd_line;
    logic            m_hit, m_partial;
    logic [CNTW-1:0] m_count;
    words_t          m_words;
    logic [TC_AW-1:0] m_next;
    rsp_t            rsp_d, rsp_q;

    tc_fill_buf u_fill (
        .clk, .rst_n, .fill_valid, .fill_pc, .fill_instr,
        .fill_is_br, .fill_taken, .fill_next,
        .wr_en, .wr_idx, .wr_line
    );

    tc_store u_store (
        .clk, .rst_n, .wr_en, .wr_idx, .wr_line,
        .rd_idx (lk_addr[IDXW-1:0]),
        .rd_line
    );

    tc_match u_match (
        .line    (rd_line),
        .lk_tag  (lk_addr[TC_AW-1:IDXW]),
        .lk_pred (lk_pred),
        .hit     (m_hit),
        .partial (m_partial),
        .count   (m_count),
        .words   (m_words),
        .next    (m_next)
    );

    always_comb begin
        rsp_d = '0;
        if (lk_valid) begin
            rsp_d.valid   = 1'b1;
            rsp_d.hit     = m_hit;
            rsp_d.partial = m_partial;
            rsp_d.cnt     = m_count;
            rsp_d.words   = m_words;
            rsp_d.next    = m_hit ? m_next : lk_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_hit     = rsp_q.hit;
    assign rsp_partial = rsp_q.partial;
    assign rsp_count   = rsp_q.cnt;
    assign rsp_words   = rsp_q.words;
    assign rsp_next    = rsp_q.next;
endmodule

// File: rtl/trace_cache_chk.sv
module trace_cache_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_partial,
    input logic [3:0]  rsp_count,
    input logic [31:0] rsp_next
);
    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    a_r3_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_count == 4'd0 && !rsp_partial));
    a_r3_miss_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit || rsp_next == $past(lk_addr)));
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_count <= 4'd8);
    a_r4_prefix_short: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_partial |-> (rsp_hit && rsp_count < 4'd8 && rsp_count != 4'd0));
endmodule

bind trace_cache trace_cache_chk u_chk (
    .clk, .rst_n, .lk_valid, .lk_addr, .rsp_valid, .rsp_hit,
    .rsp_partial, .rsp_count, .rsp_next
);

// File: tb/sim_trace_cache.sv
`timescale 1ns/1ps
module sim_trace_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_pred = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_pc = '0;
    logic [31:0] fill_instr = '0;
    logic        fill_is_br = 1'b0;
    logic        fill_taken = 1'b0;
    logic [31:0] fill_next = '0;
    logic        rsp_valid, rsp_hit, rsp_partial;
    logic [3:0]  rsp_count;
    logic [255:0] rsp_words;
    logic [31:0] rsp_next;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_cache u0 (
        .clk, .rst_n, .lk_valid, .lk_addr, .lk_pred, .fill_valid, .fill_pc,
        .fill_instr, .fill_is_br, .fill_taken, .fill_next, .rsp_valid,
        .rsp_hit, .rsp_partial, .rsp_count, .rsp_words, .rsp_next
    );

    function automatic logic [31:0] iw(input logic [31:0] pc);
        return pc ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [31:0] word_at(input int i);
        return rsp_words[i*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill_one(input logic [31:0] pc, input logic br,
                            input logic tk, input logic [31:0] nx);
        fill_valid = 1'b1; fill_pc = pc; fill_instr = iw(pc);
        fill_is_br = br; fill_taken = tk; fill_next = nx;
        @(posedge clk); @(negedge clk);
        fill_valid = 1'b0; fill_is_br = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [1:0] p);
        lk_valid = 1'b1; lk_addr = a; lk_pred = p;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a);
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " hit"}, 32'(rsp_hit), 32'd0);
        chk({req, " count"}, 32'(rsp_count), 32'd0);
        chk({req, " next"}, rsp_next, a);
    endtask

    task automatic t_reset();
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        lookup(32'h100, 2'b01);
        expect_miss("R1 empty after reset", 32'h100);
        chk("R11 idle no rsp", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        chk("R11 rsp drops", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_three_branch();
        fill_one(32'h100, 0, 0, 32'h101);
        fill_one(32'h101, 0, 0, 32'h102);
        fill_one(32'h102, 1, 1, 32'h200);
        fill_one(32'h200, 0, 0, 32'h201);
        fill_one(32'h201, 1, 0, 32'h202);
        fill_one(32'h202, 0, 0, 32'h203);
        fill_one(32'h203, 1, 1, 32'h300);
        lookup(32'h100, 2'b01);
        chk("R2 full hit", 32'(rsp_hit), 32'd1);
        chk("R2 not partial", 32'(rsp_partial), 32'd0);
        chk("R8 count at third branch", 32'(rsp_count), 32'd7);
        chk("R8 exit addr", rsp_next, 32'h300);
        chk("R2 word0", word_at(0), iw(32'h100));
        chk("R2 word3", word_at(3), iw(32'h200));
        chk("R8 last word is branch", word_at(6), iw(32'h203));
        chk("R2 unused slot zero", word_at(7), 32'h0);
        lookup(32'h100, 2'b11);
        chk("R4 partial hit", 32'(rsp_hit), 32'd1);
        chk("R4 partial flag", 32'(rsp_partial), 32'd1);
        chk("R4 prefix count", 32'(rsp_count), 32'd3);
        chk("R4 prefix next", rsp_next, 32'h200);
        chk("R4 prefix word2", word_at(2), iw(32'h102));
        chk("R4 beyond prefix zero", word_at(3), 32'h0);
        lookup(32'h100, 2'b00);
        expect_miss("R5 first mismatch", 32'h100);
        lookup(32'h110, 2'b01);
        expect_miss("R3 tag differs", 32'h110);
        lookup(32'h105, 2'b01);
        expect_miss("R3 invalid line", 32'h105);
    endtask

    task automatic t_straight();
        for (int i = 0; i < 8; i++)
            fill_one(32'h111 + 32'(i), 0, 0, 32'h112 + 32'(i));
        lookup(32'h111, 2'b10);
        chk("R7 hit no branches", 32'(rsp_hit), 32'd1);
        chk("R6 not partial", 32'(rsp_partial), 32'd0);
        chk("R7 count eight", 32'(rsp_count), 32'd8);
        chk("R7 exit addr", rsp_next, 32'h119);
        chk("R7 word7", word_at(7), iw(32'h118));
    endtask

    task automatic t_one_branch();
        fill_one(32'h122, 0, 0, 32'h123);
        fill_one(32'h123, 1, 1, 32'h400);
        for (int i = 0; i < 6; i++)
            fill_one(32'h400 + 32'(i), 0, 0, 32'h401 + 32'(i));
        lookup(32'h122, 2'b01);
        chk("R6 hit pred1=0", 32'(rsp_hit), 32'd1);
        chk("R6 count", 32'(rsp_count), 32'd8);
        chk("R6 next", rsp_next, 32'h406);
        lookup(32'h122, 2'b11);
        chk("R6 hit pred1=1", 32'(rsp_hit), 32'd1);
        chk("R6 not partial", 32'(rsp_partial), 32'd0);
        lookup(32'h122, 2'b10);
        expect_miss("R5 single branch mismatch", 32'h122);
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 7; i++)
            fill_one(32'h130 + 32'(i), 0, 0, 32'h131 + 32'(i));
        fill_valid = 1'b1; fill_pc = 32'h137; fill_instr = iw(32'h137);
        fill_is_br = 1'b0; fill_taken = 1'b0; fill_next = 32'h138;
        lk_valid = 1'b1; lk_addr = 32'h100; lk_pred = 2'b01;
        @(posedge clk); @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        chk("R9 same-cycle sees old", 32'(rsp_hit), 32'd1);
        chk("R9 old next", rsp_next, 32'h300);
        lookup(32'h100, 2'b01);
        expect_miss("R10 old trace replaced", 32'h100);
        lookup(32'h130, 2'b00);
        chk("R9 new trace visible", 32'(rsp_hit), 32'd1);
        chk("R9 new count", 32'(rsp_count), 32'd8);
        chk("R9 new next", rsp_next, 32'h138);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_three_branch();
        t_straight();
        t_one_branch();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule